// File: doc/BRIEF.md
# Timer Tick Prescaler and Per-Channel Divider

This block turns one base clock into a set of count-enable pulses, one per channel of a five-channel PWM timer. Everything stays in the base clock domain: rather than producing new clocks, the block raises each channel's enable for one base-clock cycle whenever that channel's counter may step. Two 8-bit prescale counters form the first stage. The first serves channels 0 and 1. The second serves channel 2 and every channel above it.

After the prescaler, each channel has its own 4-bit selection code. The code either applies a further power-of-two division to the prescaled tick, or it routes in an external tick input. Channels 0 and 1 take external input 0; the other channels take external input 1. External inputs are asynchronous. They pass through a two-stage synchroniser and a rising-edge detector, so each rising edge produces one enable pulse, however long the input stays high.

Software sees two configuration words through a simple write port and a combinational read port. Word address 0 holds both prescale values. Word address 1 holds the selection codes. Writing either word restarts the counters it affects, so the new setting starts from a clean phase.

Top module: `pwm_tick_gen`

## Requirements
- R1: While reset is asserted, every `tick_en` bit is 0 and both configuration words read back as 0.
- R2: Word 0 holds prescale value A in bits [7:0] and prescale value B in bits [15:8]; bits [19:16] of word 0 are not stored and read back as 0.
- R3: Word 1 holds one 4-bit selection code per channel, the code for channel c at bits [4c+3:4c]; all 20 bits read back as written.
- R4: With a selection code that divides by 1, a channel pulses once every (P+1) base cycles, where P is its group's prescale value.
- R5: Selection codes 0 to 3 divide the prescaled tick by 2^(code+DIV_BASE), giving a pulse period of (P+1)·2^(code+DIV_BASE) cycles (DIV_BASE defaults to 0).
- R6: Channels 0 and 1 use prescale value A; channels 2, 3 and 4 use prescale value B.
- R7: For any period above one cycle, each enable pulse lasts exactly one base cycle.
- R8: A write to word 0 restarts both prescalers and all dividers. After the write edge, a divided channel stays low until its first pulse, exactly N·(P+1) cycles later, where N is its division.
- R9: A write to word 1 restarts all dividers. With P = 0, the first pulse of a channel set to division N appears N cycles after the write edge.
- R10: Codes whose bit is set in the external mask parameter (default: code 4 only) select an external tick: input 0 for channels 0 and 1, input 1 for the others. Each rising edge of that input gives exactly one pulse. Other external input and the prescalers have no effect on such a channel.
- R11: Codes 5 to 15 that are not in the external mask divide by 1, giving a period of P+1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_addr | input | 1 | Word select for writes: 0 prescale word, 1 selection word |
| wr_data | input | 20 | Write data |
| rd_addr | input | 1 | Word select for reads |
| rd_data | output | 20 | Combinational read data |
| ext_tick | input | 2 | Asynchronous external tick inputs, one per channel group |
| tick_en | output | 5 | Per-channel single-cycle count enables |

## Verification
A table of configurations covers several patterns. Some use prescale values of zero, so every stage is transparent and a channel enables on every cycle. Some use different values for the two groups, which exposes any channel wired to the wrong prescaler. Some mix codes 0 to 3 across channels, so a shift that is off by one, or a code decoded from the wrong field, gives a different period on at least one channel. Undefined codes and the largest prescale value test the fall-back division and the counter width. Directed tests then measure the delay to the first pulse after each kind of write. They also drive external edges of different lengths on one input while the other stays idle, which separates one-pulse-per-edge from level following and from crossed group routing.

// File: rtl/pwm_tick_pkg.sv
package pwm_tick_pkg;

    typedef enum logic {
        CFG_PRESCALE = 1'b0,
        CFG_DIVSEL   = 1'b1
    } cfg_addr_e;

    localparam int SEL_W        = 4;
    localparam int N_GROUPS     = 2;
    localparam int GRP0_CHANNELS = 2;

    function automatic int group_of(input int ch);
        return (ch < GRP0_CHANNELS) ? 0 : 1;
    endfunction

endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [PRE_W-1:0] limit,
    output logic             tick_o
);
    typedef struct packed {
        logic [PRE_W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        tick_o = (st_q.cnt == limit);
        if (restart) begin
            st_d.cnt = '0;
        end else if (tick_o) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + PRE_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/ext_tick_sync.sv
module ext_tick_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise_o
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic prev;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.s1   = async_in;
        st_d.s2   = st_q.s1;
        st_d.prev = st_q.s2;
        rise_o    = st_q.s2 & ~st_q.prev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/tick_divider.sv
module tick_divider
    import pwm_tick_pkg::*;
#(
    parameter int          DIV_BASE = 0,
    parameter logic [15:0] EXT_MASK = 16'h0010
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             pre_tick,
    input  logic             ext_rise,
    input  logic [SEL_W-1:0] code,
    output logic             tick_o
);
    localparam int CW = 4 + DIV_BASE;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          tick;
    } st_t;

    st_t st_d, st_q;

    logic          use_ext;
    logic [2:0]    shift;
    logic [CW-1:0] last;
    logic          fire;

    always_comb begin
        use_ext = EXT_MASK[code];
        if (code[3:2] == 2'b00) shift = 3'(code[1:0]) + 3'(DIV_BASE);
        else                    shift = 3'd0;
        last = (CW'(1) << shift) - CW'(1);
        fire = pre_tick && (st_q.cnt == last);

        st_d = st_q;
        if (restart) begin
            st_d.cnt = '0;
        end else if (pre_tick) begin
            st_d.cnt = fire ? '0 : st_q.cnt + CW'(1);
        end
        st_d.tick = use_ext ? ext_rise : (fire & ~restart);
        tick_o    = st_q.tick;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen
    import pwm_tick_pkg::*;
#(
    parameter int          NUM_CH   = 5,
    parameter int          PRE_W    = 8,
    parameter int          DIV_BASE = 0,
    parameter logic [15:0] EXT_MASK = 16'h0010,
    localparam int PRE_BITS = N_GROUPS * PRE_W,
    localparam int SEL_BITS = NUM_CH * SEL_W,
    localparam int REG_W    = (PRE_BITS > SEL_BITS) ? PRE_BITS : SEL_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic              rd_addr,
    output logic [REG_W-1:0]  rd_data,
    input  logic [1:0]        ext_tick,
    output logic [NUM_CH-1:0] tick_en
);
    typedef struct packed {
        logic [PRE_BITS-1:0] pre;
        logic [SEL_BITS-1:0] sel;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    logic                pre_restart;
    logic                div_restart;
    logic [N_GROUPS-1:0] pre_tick;
    logic [N_GROUPS-1:0] ext_rise;
    logic [PRE_BITS-1:0] pre_word_q;
    logic [SEL_BITS-1:0] sel_word_q;

    always_comb begin
        cfg_d       = cfg_q;
        pre_restart = 1'b0;
        div_restart = 1'b0;
        if (wr_en) begin
            div_restart = 1'b1;
            if (cfg_addr_e'(wr_addr) == CFG_PRESCALE) begin
                cfg_d.pre   = wr_data[PRE_BITS-1:0];
                pre_restart = 1'b1;
            end else begin
                cfg_d.sel = wr_data[SEL_BITS-1:0];
            end
        end
        if (cfg_addr_e'(rd_addr) == CFG_PRESCALE) rd_data = REG_W'(cfg_q.pre);
        else                                      rd_data = REG_W'(cfg_q.sel);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign pre_word_q = cfg_q.pre;
    assign sel_word_q = cfg_q.sel;

    for (genvar g = 0; g < N_GROUPS; g++) begin : g_grp
        tick_prescaler #(.PRE_W(PRE_W)) u_pre (
            .clk     (clk),
            .rst_n   (rst_n),
            .restart (pre_restart),
            .limit   (cfg_q.pre[g*PRE_W +: PRE_W]),
            .tick_o  (pre_tick[g])
        );
        ext_tick_sync u_sync (
            .clk      (clk),
            .rst_n    (rst_n),
            .async_in (ext_tick[g]),
            .rise_o   (ext_rise[g])
        );
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        localparam int GRP = group_of(c);
        tick_divider #(.DIV_BASE(DIV_BASE), .EXT_MASK(EXT_MASK)) u_div (
            .clk      (clk),
            .rst_n    (rst_n),
            .restart  (div_restart),
            .pre_tick (pre_tick[GRP]),
            .ext_rise (ext_rise[GRP]),
            .code     (cfg_q.sel[c*SEL_W +: SEL_W]),
            .tick_o   (tick_en[c])
        );
    end
endmodule

// File: rtl/pwm_tick_gen_chk.sv
module pwm_tick_gen_chk #(
    parameter int          NUM_CH   = 5,
    parameter int          PRE_BITS = 16,
    parameter int          REG_W    = 20,
    parameter logic [15:0] EXT_MASK = 16'h0010
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  wr_en,
    input logic                  wr_addr,
    input logic [REG_W-1:0]      wr_data,
    input logic [PRE_BITS-1:0]   pre_word_q,
    input logic [NUM_CH*4-1:0]   sel_word_q,
    input logic [NUM_CH-1:0]     tick_en
);
    logic [NUM_CH-1:0] ext_sel;

    always_comb begin
        for (int c = 0; c < NUM_CH; c++) ext_sel[c] = EXT_MASK[sel_word_q[c*4 +: 4]];
    end

    AST_PRE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_addr) |=> (pre_word_q == $past(wr_data[PRE_BITS-1:0]))); // R2

    AST_SEL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr) |=> (sel_word_q == $past(wr_data[NUM_CH*4-1:0]))); // R3

    AST_RESTART_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en) |-> ((tick_en & ~$past(ext_sel)) == '0)); // R8

    AST_EXT_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ((tick_en & $past(tick_en) & ext_sel & $past(ext_sel)) == '0)); // R10
endmodule

bind pwm_tick_gen pwm_tick_gen_chk #(
    .NUM_CH(NUM_CH), .PRE_BITS(PRE_BITS), .REG_W(REG_W), .EXT_MASK(EXT_MASK)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .pre_word_q (pre_word_q),
    .sel_word_q (sel_word_q),
    .tick_en    (tick_en)
);

// File: tb/sim_pwm_tick_gen.sv
`timescale 1ns/1ps
module sim_pwm_tick_gen;
    localparam int NCH = 5;
    localparam int RW  = 20;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           wr_en = 1'b0;
    logic           wr_addr = 1'b0;
    logic [RW-1:0]  wr_data = '0;
    logic           rd_addr = 1'b0;
    logic [RW-1:0]  rd_data;
    logic [1:0]     ext_tick = 2'b00;
    logic [NCH-1:0] tick_en;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    pwm_tick_gen u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .ext_tick(ext_tick), .tick_en(tick_en)
    );

    // {prescale word [15:0], selection codes [19:0]}
    localparam logic [35:0] VEC [5] = '{
        {16'h0000, 20'h00000},
        {16'h0103, 20'h13210},
        {16'h0401, 20'h90123},
        {16'h0009, 20'hF2302},
        {16'h02FF, 20'h31000}
    };

    task automatic check(input string req, input int act, input int exp_v);
        n_chk++;
        if (act != exp_v) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    task automatic wr(input logic a, input logic [RW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic int exp_period(input logic [15:0] pre, input logic [3:0] code, input int ch);
        int p = (ch < 2) ? int'(pre[7:0]) : int'(pre[15:8]);
        if (code < 4) return (p + 1) << code;
        return p + 1;
    endfunction

    task automatic measure(input int ch, output int per, output int wid_ok);
        int guard = 0;
        per = -1; wid_ok = 1;
        while (!tick_en[ch] && guard < 5000) begin @(negedge clk); guard++; end
        if (guard >= 5000) return;
        @(negedge clk);
        per = 1;
        wid_ok = 1;
        if (tick_en[ch]) begin
            wid_ok = 0;
        end
        while (!tick_en[ch] && per < 5000) begin @(negedge clk); per++; end
    endtask

    task automatic count_pulses(input int cycles, output int c0, output int c1, output int c3);
        c0 = 0; c1 = 0; c3 = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            c0 += int'(tick_en[0]); c1 += int'(tick_en[1]); c3 += int'(tick_en[3]);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        int per, wok, cnt, a0, a1, a3;
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 tick_en in reset", int'(tick_en), 0);
        rd_addr = 1'b0; #1 check("R1 word0 in reset", int'(rd_data), 0);
        rd_addr = 1'b1; #1 check("R1 word1 in reset", int'(rd_data), 0);
        @(negedge clk); rst_n = 1'b1;

        // table walk: R2 R3 R4 R5 R6 R7 R11
        for (int v = 0; v < 5; v++) begin
            logic [15:0] pw = VEC[v][35:20];
            logic [19:0] sw = VEC[v][19:0];
            wr(1'b0, {4'hF, pw});
            wr(1'b1, sw);
            rd_addr = 1'b0; #1 check("R2 word0 readback", int'(rd_data), int'(pw));
            rd_addr = 1'b1; #1 check("R3 word1 readback", int'(rd_data), int'(sw));
            for (int c = 0; c < NCH; c++) begin
                int e = exp_period(pw, sw[c*4 +: 4], c);
                measure(c, per, wok);
                check($sformatf("R4/R5/R6/R11 period ch%0d vec%0d", c, v), per, e);
                if (e > 1) check($sformatf("R7 width ch%0d vec%0d", c, v), wok, 1);
            end
        end

        // R8: first pulse after prescale write, P=3, code 2 -> 16 cycles after edge
        wr(1'b1, 20'h00002);
        @(negedge clk); wr_en = 1'b1; wr_addr = 1'b0; wr_data = 20'h00003;
        @(negedge clk); wr_en = 1'b0;
        cnt = 1;
        while (!tick_en[0] && cnt < 1000) begin @(negedge clk); cnt++; end
        check("R8 first pulse delay after word0 write", cnt - 1, 16);

        // R9: first pulse after selection write, P=0, code 3 -> 8 cycles after edge
        wr(1'b0, 20'h00000);
        @(negedge clk); wr_en = 1'b1; wr_addr = 1'b1; wr_data = 20'h00003;
        @(negedge clk); wr_en = 1'b0;
        cnt = 1;
        while (!tick_en[0] && cnt < 1000) begin @(negedge clk); cnt++; end
        check("R9 first pulse delay after word1 write", cnt - 1, 8);

        // R10: external ticks, code 4 on ch0, ch1, ch3
        wr(1'b0, 20'h00505);
        wr(1'b1, 20'h04044);
        repeat (5) @(negedge clk);
        fork
            begin
                for (int k = 0; k < 3; k++) begin
                    @(negedge clk); ext_tick[0] = 1'b1;
                    repeat (2 + 3 * k) @(negedge clk);
                    ext_tick[0] = 1'b0;
                    repeat (4) @(negedge clk);
                end
            end
            count_pulses(60, a0, a1, a3);
        join
        check("R10 ch0 pulses on ext0", a0, 3);
        check("R10 ch1 pulses on ext0", a1, 3);
        check("R10 ch3 ignores ext0 and prescaler", a3, 0);
        fork
            begin
                @(negedge clk); ext_tick[1] = 1'b1;
                repeat (6) @(negedge clk);
                ext_tick[1] = 1'b0;
            end
            count_pulses(30, a0, a1, a3);
        join
        check("R10 ch3 pulses on ext1", a3, 1);
        check("R10 ch0 ignores ext1", a0, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule